// File: doc/BRIEF.md
# Three-Channel Temperature Sampling Controller

This block manages three temperature sensor channels behind a 32-bit register port. A free-running interval timer sets a conversion slot once every N+1 clock cycles. In each slot the controller takes one sample from the next enabled channel in rotation. Disabled channels are passed over and keep the last value they produced. Each channel has its own 12-bit result register.

An optional averaging stage collects a power-of-two number of samples per channel before it publishes their mean. Each published result is compared against two thresholds held in a calibration register, a shutdown limit and an alarm limit. A lower raw code means a hotter die, so both compares are "strictly less than". Three classes of event, data-ready, alarm and shutdown, are recorded per channel in a write-one-to-clear status register. A single level interrupt is raised while any recorded event has its enable bit set.

The sample input stands in for the analog front end. The calibration words and the second control words are plain storage; only calibration word 0 feeds the threshold compares.

Top module: `thermal_monitor`

## Requirements
- R1: After reset every register reads 0 and irq is low.
- R2: Read-back masks: 0x00 keeps bits 15:0, 0x04 keeps only bit 17, 0x40 keeps bits 31:16 and 2:0, 0x44 keeps bits 31:12, 10:8, 6:4 and 2:0, 0x70 keeps bits 2:0, and 0x74 and 0x78 keep all 32 bits. Unkept bits read as 0.
- R3: Writing 0x00 with N restarts the interval. The first conversion slot falls on the (N+1)-th rising edge after the write edge, and the following slots come every N+1 cycles.
- R4: Each slot converts exactly one enabled channel. Channels are taken in rotation 0, 1, 2, starting at channel 0 after reset. Channel c is enabled by bit c of 0x40.
- R5: A channel whose enable bit is clear is skipped, and its data register keeps its last value.
- R6: Channel c's result reads at 0x80+4c in bits 11:0, with bits 31:12 zero. Publishing a result sets status bit 8+c (data-ready).
- R7: A published result below 0x74[11:0] sets status bit 4+c (shutdown). A result below 0x74[27:16] sets status bit c (alarm). A result equal to a limit sets neither flag.
- R8: Status is at 0x48. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as the clear wins.
- R9: When 0x70 bit 2 is set, a channel publishes only on every 2^(1+F)-th conversion, where F is 0x70[1:0]. It publishes floor(sum/2^(1+F)) of those samples. Writing 0x70 discards partial sums.
- R10: irq is high exactly while some status bit is 1 and the bit at the same position of 0x44 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (8) | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| smp_in | input | NCH*SW (36) | Per-channel raw sample, channel c at bits c*SW +: SW |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is the last sample of an averaging window. The bench only sees a result after a whole window of slots has passed, so it must know exactly which sample each slot captured. The stimulus restarts the interval by writing N and then changes the sample once per N+1 cycles, aligned to the predicted slot edges. This makes every captured value known and the mean computable. Round-robin skipping is reached by enabling a non-contiguous channel set, with the rotation pointer freshly reset.

// File: rtl/thermal_monitor.sv
module thermal_monitor #(
  parameter int NCH  = 3,
  parameter int SW   = 12,
  parameter int AW   = 8,
  parameter int CNTW = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCH*SW-1:0] smp_in,
  output logic              irq
);
  localparam int ACCW = SW + 4;
  localparam int PW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] A_ACQ = AW'(8'h00);
  localparam logic [AW-1:0] A_CT1 = AW'(8'h04);
  localparam logic [AW-1:0] A_CT2 = AW'(8'h40);
  localparam logic [AW-1:0] A_IEN = AW'(8'h44);
  localparam logic [AW-1:0] A_STS = AW'(8'h48);
  localparam logic [AW-1:0] A_FLT = AW'(8'h70);
  localparam logic [AW-1:0] A_CL0 = AW'(8'h74);
  localparam logic [AW-1:0] A_CL1 = AW'(8'h78);
  localparam logic [AW-1:0] A_DAT = AW'(8'h80);
  localparam logic [31:0]   IEN_MASK = 32'hFFFF_F777;
  localparam logic [11:0]   STS_MASK = 12'h777;

  logic [CNTW-1:0]          acq_n, tmr;
  logic                     cal_en;
  logic [15:0]              acq2;
  logic [NCH-1:0]           ch_en;
  logic [31:0]              ien;
  logic [11:0]              sts, sts_set;
  logic [2:0]               flt;
  logic [31:0]              cal0, cal1;
  logic [NCH-1:0][SW-1:0]   res;
  logic [NCH-1:0][ACCW-1:0] acc;
  logic [NCH-1:0][3:0]      cnt;
  logic [PW-1:0]            ptr, pick;
  logic                     found, tick, fire, last, done;
  logic [SW-1:0]            sample, val;
  logic [ACCW-1:0]          sum;
  logic [2:0]               dlog;

  wire wr_acq = reg_we && reg_addr == A_ACQ;
  wire wr_sts = reg_we && reg_addr == A_STS;
  wire wr_flt = reg_we && reg_addr == A_FLT;

  assign tick = (tmr == acq_n);
  assign fire = tick && found;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NCH; k++) begin
      if (!found && ch_en[(int'(ptr) + k) % NCH]) begin
        found = 1'b1;
        pick  = PW'((int'(ptr) + k) % NCH);
      end
    end
  end

  assign sample = smp_in[int'(pick)*SW +: SW];
  assign dlog   = {1'b0, flt[1:0]} + 3'd1;
  assign last   = {1'b0, cnt[pick]} == ((5'd2 << flt[1:0]) - 5'd1);
  assign sum    = acc[pick] + ACCW'(sample);
  assign val    = flt[2] ? SW'(sum >> dlog) : sample;
  assign done   = fire && (!flt[2] || last);

  always_comb begin
    sts_set = '0;
    if (done) begin
      sts_set[8 + int'(pick)] = 1'b1;
      if (val < cal0[SW-1:0])     sts_set[4 + int'(pick)] = 1'b1;
      if (val < cal0[16 +: SW])   sts_set[int'(pick)]     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_n <= '0; tmr <= '0; cal_en <= 1'b0; acq2 <= '0; ch_en <= '0;
      ien <= '0; sts <= '0; flt <= '0; cal0 <= '0; cal1 <= '0; ptr <= '0;
    end else begin
      if (wr_acq)      tmr <= '0;
      else if (tick)   tmr <= '0;
      else             tmr <= tmr + 1'b1;
      if (fire) ptr <= (int'(pick) == NCH-1) ? '0 : pick + 1'b1;
      sts <= (sts & ~(wr_sts ? reg_wdata[11:0] : 12'h0) | sts_set) & STS_MASK;
      if (reg_we) begin
        case (reg_addr)
          A_ACQ: acq_n  <= reg_wdata[CNTW-1:0];
          A_CT1: cal_en <= reg_wdata[17];
          A_CT2: begin acq2 <= reg_wdata[31:16]; ch_en <= reg_wdata[NCH-1:0]; end
          A_IEN: ien    <= reg_wdata & IEN_MASK;
          A_FLT: flt    <= reg_wdata[2:0];
          A_CL0: cal0   <= reg_wdata;
          A_CL1: cal1   <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0; acc <= '0; cnt <= '0;
    end else begin
      if (wr_flt) begin
        acc <= '0;
        cnt <= '0;
      end else if (fire && flt[2]) begin
        acc[pick] <= last ? '0 : sum;
        cnt[pick] <= last ? '0 : cnt[pick] + 4'd1;
      end
      if (done) res[pick] <= val;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ACQ: reg_rdata = 32'(acq_n);
      A_CT1: reg_rdata = {14'b0, cal_en, 17'b0};
      A_CT2: reg_rdata = {acq2, 16'(ch_en)};
      A_IEN: reg_rdata = ien;
      A_STS: reg_rdata = {20'b0, sts};
      A_FLT: reg_rdata = {29'b0, flt};
      A_CL0: reg_rdata = cal0;
      A_CL1: reg_rdata = cal1;
      default: begin
        for (int c = 0; c < NCH; c++)
          if (reg_addr == A_DAT + AW'(4*c)) reg_rdata = 32'(res[c]);
      end
    endcase
  end

  assign irq = |(sts & ien[11:0]);
endmodule

// File: rtl/thermal_monitor_chk.sv
module thermal_monitor_chk #(
  parameter int NCH = 3,
  parameter int SW  = 12
)(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   irq,
  input logic [11:0]            sts,
  input logic [NCH-1:0]         ch_en,
  input logic [NCH-1:0][SW-1:0] res
);
  AST_ONE_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sts[8 +: NCH] & ~$past(sts[8 +: NCH]))); // R4
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts != 12'h0)); // R10

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    AST_SKIP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[c] |=> $stable(res[c])); // R5
    AST_READY_FROM_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[8+c]) |-> $past(ch_en[c])); // R4
    AST_SHUT_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[4+c]) |-> sts[8+c]); // R7
  end
endmodule

bind thermal_monitor thermal_monitor_chk #(.NCH(NCH), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .sts(sts), .ch_en(ch_en), .res(res));

// File: tb/thermal_monitor_test.sv
module thermal_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int SW  = 12;

  logic              clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [7:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0, reg_rdata;
  logic [NCH*SW-1:0] smp_in = '0;
  logic              irq;
  int checks = 0, errors = 0, cyc = 0;

  thermal_monitor uut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_in(smp_in), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; smp_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_bit(int b, output int at);
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(8'h48, s);
      if (s[b]) begin at = cyc; return; end
      @(negedge clk);
    end
    at = -1;
    chk("wait_bit timeout", 0, 1);
  endtask

  function automatic logic [31:0] exp_sts(int c, int v, int sh, int al);
    return (32'h1 << (8+c)) | ((v < sh) ? 32'h1 << (4+c) : 0) | ((v < al) ? 32'h1 << c : 0);
  endfunction

  task automatic set_smp(int c, int v);
    smp_in[c*SW +: SW] = SW'(v);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int t0, t1, sum, va, vb;
    logic [7:0] regs [11] = '{8'h00,8'h04,8'h40,8'h44,8'h48,8'h70,8'h74,8'h78,8'h80,8'h84,8'h88};
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset();

    // R1 reset state
    foreach (regs[i]) begin rd(regs[i], r); chk("R1 reset reg", r, 0); end
    chk("R1 irq after reset", 32'(irq), 0);

    // R2 read-back masks
    wr(8'h00, 32'hFFFF_1234); rd(8'h00, r); chk("R2 ctl0", r, 32'h1234);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, r); chk("R2 ctl1", r, 32'h0002_0000);
    wr(8'h40, 32'hABCD_FFF8); rd(8'h40, r); chk("R2 ctl2", r, 32'hABCD_0000);
    wr(8'h44, 32'h0001_8000); rd(8'h44, r); chk("R2 int cfg", r, 32'h0001_8000);
    wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, r); chk("R2 int mask", r, 32'hFFFF_F777);
    wr(8'h70, 32'h0000_00FE); rd(8'h70, r); chk("R2 filter", r, 32'h6);
    wr(8'h78, 32'h5A5A_C3C3); rd(8'h78, r); chk("R2 cal1", r, 32'h5A5A_C3C3);
    do_reset();

    // R3 interval period
    wr(8'h00, 1000); wr(8'h40, 1); wr(8'h00, 5);
    wait_bit(8, t0); wr(8'h48, 32'h100); wait_bit(8, t1);
    chk("R3 slot period", t1 - t0, 6);
    do_reset();

    // R4/R5 rotation with channel 1 disabled
    va = 12'h5A1; vb = 12'h0C3;
    set_smp(0, va); set_smp(1, 12'h777); set_smp(2, vb);
    wr(8'h00, 1000); wr(8'h40, 5); wr(8'h00, 3);
    wait_bit(8, t0); rd(8'h48, r); chk("R4 first slot channel 0", r, 32'h100);
    wait_bit(10, t1); rd(8'h48, r); chk("R4 second slot channel 2", r, 32'h500);
    chk("R4 slot spacing", t1 - t0, 4);
    wr(8'h48, 32'h500); wait_bit(8, t0); rd(8'h48, r); chk("R4 wraps to channel 0", r, 32'h100);
    rd(8'h84, r); chk("R5 skipped channel keeps value", r, 0);
    rd(8'h80, r); chk("R6 data ch0", r, 32'(va));
    rd(8'h88, r); chk("R6 data ch2", r, 32'(vb));
    wr(8'h40, 4); set_smp(0, 12'h111);
    repeat (20) @(negedge clk);
    rd(8'h80, r); chk("R5 disabled channel holds", r, 32'(va));
    do_reset();

    // R7/R8/R10 thresholds, write-one-to-clear, irq
    wr(8'h00, 1000); wr(8'h74, (32'h800 << 16) | 32'h400); wr(8'h44, 32'h10);
    wr(8'h40, 1); set_smp(0, 12'h3FF); wr(8'h00, 2);
    repeat (3) @(posedge clk); @(negedge clk);
    wr(8'h00, 1000);
    rd(8'h48, r); chk("R7 below both limits", r, 32'h111);
    chk("R10 irq with enabled shutdown", 32'(irq), 1);
    wr(8'h48, 32'h010); rd(8'h48, r); chk("R8 clear one bit only", r, 32'h101);
    chk("R10 irq drops after clear", 32'(irq), 0);
    wr(8'h48, 32'h0); rd(8'h48, r); chk("R8 zero write no effect", r, 32'h101);
    wr(8'h44, 32'h100); chk("R10 irq data-ready enable", 32'(irq), 1);
    wr(8'h44, 0); wr(8'h48, 32'h777);
    set_smp(0, 12'h400); wr(8'h00, 2);
    repeat (3) @(posedge clk); @(negedge clk);
    wr(8'h00, 1000);
    rd(8'h48, r); chk("R7 equal to shutdown limit", r, 32'h101);
    do_reset();

    // R9 averaging for two depths
    for (int d = 0; d < 3; d += 2) begin
      wr(8'h00, 1000); wr(8'h40, 1); wr(8'h70, 4 | d); wr(8'h00, 2);
      sum = 0;
      for (int i = 0; i < (2 << d); i++) begin
        va = $urandom % 4096; sum += va; set_smp(0, va);
        if (i == (2 << d) - 1) begin rd(8'h48, r); chk("R9 no result before window end", r, 0); end
        repeat (3) @(posedge clk); @(negedge clk);
      end
      wr(8'h00, 1000);
      rd(8'h80, r); chk("R9 averaged result", r, 32'(sum >> (1 + d)));
      rd(8'h48, r); chk("R9 data-ready at window end", r & 32'h100, 32'h100);
      wr(8'h48, 32'h777);
    end
    do_reset();

    // R3/R6/R7 random single conversions, filter off
    for (int n = 0; n < 24; n++) begin
      int c, v, sh, al, nn;
      c = $urandom % 3; v = $urandom % 4096; nn = 1 + $urandom % 6;
      sh = v + ($urandom % 5) - 2; al = v + ($urandom % 7) - 3;
      if (sh < 0) sh = 0; if (al < 0) al = 0;
      if (sh > 4095) sh = 4095; if (al > 4095) al = 4095;
      wr(8'h00, 1000); wr(8'h48, 32'h777);
      wr(8'h74, (32'(al) << 16) | 32'(sh)); wr(8'h40, 32'h1 << c);
      set_smp(c, v); wr(8'h00, 32'(nn));
      repeat (nn) @(posedge clk); @(negedge clk);
      rd(8'h48, r); chk("R3 no slot before N+1 edges", r, 0);
      @(posedge clk); @(negedge clk);
      rd(8'h48, r); chk("R7 random flags", r, exp_sts(c, v, sh, al));
      rd(8'h80 + 8'(4*c), r); chk("R6 random data", r, 32'(v));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule